// File: doc/BRIEF.md
# Match-Channel System Timer

This block is a system timer that software reaches over a simple 32-bit register bus. A counter runs upward by one on every cycle where the tick enable input is high, so the time base can be slower than the bus clock. Four comparators watch the count. When the count reaches a channel's stored value on a tick, that channel latches a status flag.

Each latched flag drives an interrupt line only while the enable bit for that channel is set. Software acknowledges an event by writing a one to the flag's position in the status word. The last channel can also act as a watchdog. Once software arms the watchdog enable bit, a match on that channel produces a single-cycle reset pulse. After that, only a block reset can disarm the watchdog.

A typical driver works in a few steps. It reads the count and adds a delay of at least 16 ticks, because a compare value already passed is not seen again until the counter wraps. It writes the result to a match register and sets the enable bit. When the interrupt arrives, it clears the flag.

Top module: `ostmr_top`

## Requirements
- R1: After reset the counter reads 0, every match register reads all ones, and the status, interrupt enable and watchdog enable words read 0. All interrupt outputs and the watchdog reset output are low.
- R2: On each clock edge where `tick_en` is high and the counter is not being written, the count rises by one and wraps from all ones to 0. When `tick_en` is low, the count holds.
- R3: A write to byte offset 0x10 loads the counter, and a read there returns the current count.
- R4: Match register n sits at byte offset 4*n (0x00, 0x04, 0x08, 0x0C) and reads back what was written.
- R5: Status bit n (offset 0x14, bits 0 to 3) becomes 1 after a ticking edge where the count equals match register n, whatever the enable state. A compare value the count has already passed does not set the bit.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it alone. One write may clear several bits. A status write never sets a bit.
- R7: Interrupt output n is high exactly while status bit n and enable bit n (offset 0x1C) are both 1. Clearing the enable bit drops the output and leaves the status bit set.
- R8: When bit 0 of the watchdog enable word (offset 0x18) is 1, a channel 3 match drives `wdt_rst_o` high for exactly one cycle, in the cycle where status bit 3 first reads 1. When that bit is 0, a channel 3 match gives no pulse.
- R9: The watchdog enable bit, once set, stays set when 0 is written to it, and is cleared only by reset.
- R10: Reads of unmapped or misaligned offsets (low two address bits not zero, or beyond 0x1C) return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Counter advance strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for `bus_addr`, combinational |
| irq_o | output | NCH (4) | Per-channel interrupt levels |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The bound checker watches several rules on every cycle:
- each ticking edge advances the count by exactly one, and a non-ticking edge holds it;
- a compare hit always shows up in the status word on the next cycle;
- status bits rise only after a hit and fall only after a status write;
- the watchdog enable never drops;
- every reset pulse is caused by an armed channel 3 hit.

Other behaviour needs the directed scenarios, which observe it through the bus:
- which bits a given write value clears;
- that a compare value already passed is missed while one 16 ticks ahead is caught;
- that the pulse lasts one cycle;
- that writes to unmapped or misaligned offsets leave every register untouched.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;

  // Fixed byte offsets; match channels occupy 4*n below the counter.
  localparam logic [31:0] OFS_COUNT  = 32'h10;
  localparam logic [31:0] OFS_STATUS = 32'h14;
  localparam logic [31:0] OFS_WDOG   = 32'h18;
  localparam logic [31:0] OFS_IRQEN  = 32'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MATCH,
    SEL_COUNT,
    SEL_STATUS,
    SEL_WDOG,
    SEL_IRQEN
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [31:0] ofs, input int unsigned nch);
    if (ofs[1:0] != 2'b00) return SEL_NONE;
    if (ofs < 32'(4 * nch)) return SEL_MATCH;
    case (ofs)
      OFS_COUNT:  return SEL_COUNT;
      OFS_STATUS: return SEL_STATUS;
      OFS_WDOG:   return SEL_WDOG;
      OFS_IRQEN:  return SEL_IRQEN;
      default:    return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             adv
);

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  // A load takes priority over a tick on the same edge.
  assign adv = tick_en && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (load)    count <= load_val;
    else if (tick_en) count <= next_count(count);
  end

endmodule

// File: rtl/ostmr_chan.sv
module ostmr_chan #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [CNT_W-1:0] count,
  input  logic             match_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             clr,
  input  logic             irq_en,
  output logic [CNT_W-1:0] match_q,
  output logic             hit,
  output logic             status,
  output logic             irq
);

  function automatic logic f_hit(input logic a, input logic [CNT_W-1:0] c,
                                 input logic [CNT_W-1:0] m);
    return a && (c == m);
  endfunction

  // A hit in the same cycle as a clear wins, so no event is lost.
  function automatic logic f_status(input logic cur, input logic c, input logic h);
    return (cur && !c) || h;
  endfunction

  assign hit = f_hit(adv, count, match_q);
  assign irq = status && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '1;
      status  <= 1'b0;
    end else begin
      if (match_wr) match_q <= wdata;
      status <= f_status(status, clr, hit);
    end
  end

endmodule

// File: rtl/ostmr_wdog.sv
module ostmr_wdog (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_wr,
  input  logic arm_bit,
  input  logic trig,
  output logic armed,
  output logic rst_pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      if (arm_wr && arm_bit) armed <= 1'b1;
      rst_pulse <= armed && trig;
    end
  end

endmodule

// File: rtl/ostmr_top.sv
module ostmr_top #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    irq_o,
  output logic              wdt_rst_o
);
  import ostmr_pkg::*;

  localparam int unsigned IDX_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned WDT_CH = NCH - 1;

  reg_sel_e               sel;
  logic [IDX_W-1:0]       ch_idx;
  logic                   cnt_wr, stat_wr, wdog_wr, ien_wr;
  logic [CNT_W-1:0]       cnt;
  logic                   cnt_adv;
  logic [NCH-1:0]         hit_vec, stat_vec, ien_q;
  logic [CNT_W-1:0]       match_arr [NCH];
  logic                   wde_q;

  always_comb begin
    sel    = decode_sel(32'(bus_addr), NCH);
    ch_idx = bus_addr[2 +: IDX_W];
  end

  assign cnt_wr  = bus_wr && (sel == SEL_COUNT);
  assign stat_wr = bus_wr && (sel == SEL_STATUS);
  assign wdog_wr = bus_wr && (sel == SEL_WDOG);
  assign ien_wr  = bus_wr && (sel == SEL_IRQEN);

  ostmr_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load(cnt_wr),
    .load_val(bus_wdata), .count(cnt), .adv(cnt_adv)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic m_wr;
    assign m_wr = bus_wr && (sel == SEL_MATCH) && (ch_idx == IDX_W'(n));
    ostmr_chan #(.CNT_W(CNT_W)) ch_i (
      .clk(clk), .rst_n(rst_n), .adv(cnt_adv), .count(cnt),
      .match_wr(m_wr), .wdata(bus_wdata),
      .clr(stat_wr && bus_wdata[n]), .irq_en(ien_q[n]),
      .match_q(match_arr[n]), .hit(hit_vec[n]),
      .status(stat_vec[n]), .irq(irq_o[n])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_wr) ien_q <= bus_wdata[NCH-1:0];
  end

  ostmr_wdog wdog_i (
    .clk(clk), .rst_n(rst_n), .arm_wr(wdog_wr), .arm_bit(bus_wdata[0]),
    .trig(hit_vec[WDT_CH]), .armed(wde_q), .rst_pulse(wdt_rst_o)
  );

  always_comb begin
    case (sel)
      SEL_MATCH:  bus_rdata = match_arr[ch_idx];
      SEL_COUNT:  bus_rdata = cnt;
      SEL_STATUS: bus_rdata = CNT_W'(stat_vec);
      SEL_WDOG:   bus_rdata = CNT_W'(wde_q);
      SEL_IRQEN:  bus_rdata = CNT_W'(ien_q);
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ostmr_chk.sv
module ostmr_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned NCH   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt,
  input logic [NCH-1:0]   hit,
  input logic [NCH-1:0]   status,
  input logic             stat_wr,
  input logic             wde,
  input logic             wdt_rst
);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_wr) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_wr) |=> $stable(cnt));

  // R5
  hit_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((status & $past(hit)) == $past(hit)));

  // R6
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|hit) |=> ((status & ~$past(status)) == '0));

  // R6
  clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> (($past(status) & ~status) == '0));

  // R9
  wdog_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wde |=> wde);

  // R8
  wdog_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(wde && hit[NCH-1]));

endmodule

bind ostmr_top ostmr_chk #(.CNT_W(CNT_W), .NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr(cnt_wr), .cnt(cnt),
  .hit(hit_vec), .status(stat_vec), .stat_wr(stat_wr), .wde(wde_q),
  .wdt_rst(wdt_rst_o)
);

// File: tb/ostmr_top_tb_top.sv
module ostmr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_o;
  logic        wdt_rst_o;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ostmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
  );

  always @(negedge clk) if (rst_n && wdt_rst_o) pulses++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h10, d); check("R1 count", d, 0);
    for (int n = 0; n < 4; n++) begin
      rd(8'(4*n), d); check("R1 match", d, 32'hFFFF_FFFF);
    end
    rd(8'h14, d); check("R1 status", d, 0);
    rd(8'h18, d); check("R1 wdog", d, 0);
    rd(8'h1C, d); check("R1 irqen", d, 0);
    check("R1 outputs", {27'd0, wdt_rst_o, irq_o}, 0);
  endtask

  task automatic t_counter();
    logic [31:0] d;
    wr(8'h10, 32'd100);
    rd(8'h10, d); check("R3 load", d, 100);
    repeat (5) @(negedge clk);
    rd(8'h10, d); check("R2 hold", d, 100);
    ticks(5);
    rd(8'h10, d); check("R2 advance", d, 105);
    wr(8'h10, 32'hFFFF_FFFE);
    ticks(3);
    rd(8'h10, d); check("R2 wrap", d, 1);
  endtask

  task automatic t_match_irq();
    logic [31:0] d;
    for (int n = 0; n < 4; n++) wr(8'(4*n), 32'd200 + 32'(n));
    for (int n = 0; n < 4; n++) begin
      rd(8'(4*n), d); check("R4 readback", d, 32'd200 + 32'(n));
    end
    wr(8'h10, 32'd195);
    ticks(10);
    rd(8'h14, d); check("R5 status set", d, 32'hF);
    check("R7 irq gated off", {28'd0, irq_o}, 0);
    wr(8'h1C, 32'h5);
    #1 check("R7 irq on", {28'd0, irq_o}, 32'h5);
    wr(8'h1C, 32'h4);
    #1 check("R7 irq disarm", {28'd0, irq_o}, 32'h4);
    rd(8'h14, d); check("R7 status kept", d, 32'hF);
    check("R8 no pulse unarmed", pulses, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(8'h14, 32'h2);
    rd(8'h14, d); check("R6 clear one", d, 32'hD);
    wr(8'h14, 32'h0);
    rd(8'h14, d); check("R6 zero no effect", d, 32'hD);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); check("R6 clear all", d, 0);
    wr(8'h14, 32'hF);
    rd(8'h14, d); check("R6 write never sets", d, 0);
    check("R7 irq after clear", {28'd0, irq_o}, 0);
    wr(8'h1C, 32'h0);
  endtask

  task automatic t_lead();
    logic [31:0] d;
    wr(8'h00, 32'd299);
    wr(8'h10, 32'd300);
    ticks(20);
    rd(8'h14, d); check("R5 passed compare missed", d, 0);
    wr(8'h00, 32'd316);
    wr(8'h10, 32'd300);
    ticks(20);
    rd(8'h14, d); check("R5 lead of 16 caught", d, 1);
    wr(8'h14, 32'h1);
  endtask

  task automatic t_unmapped();
    logic [31:0] d, c0;
    rd(8'h10, c0);
    wr(8'h20, 32'h1234);
    wr(8'h11, 32'h7);
    wr(8'h02, 32'h55);
    rd(8'h10, d); check("R10 counter untouched", d, c0);
    rd(8'h00, d); check("R10 match untouched", d, 32'd316);
    rd(8'h20, d); check("R10 read beyond map", d, 0);
    rd(8'h11, d); check("R10 misaligned read", d, 0);
  endtask

  task automatic t_wdog();
    logic [31:0] d;
    wr(8'h0C, 32'd505);
    wr(8'h10, 32'd500);
    ticks(10);
    rd(8'h14, d); check("R8 ch3 status", d, 32'h8);
    check("R8 no pulse unarmed", pulses, 0);
    wr(8'h18, 32'h1);
    rd(8'h18, d); check("R8 armed readback", d, 1);
    wr(8'h14, 32'hF);
    wr(8'h10, 32'd500);
    ticks(10);
    @(negedge clk);
    check("R8 one-cycle pulse", pulses, 1);
    wr(8'h18, 32'h0);
    rd(8'h18, d); check("R9 sticky enable", d, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_counter();
    t_match_irq();
    t_w1c();
    t_lead();
    t_unmapped();
    t_wdog();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule